// File: doc/BRIEF.md
# Audio Transmit Block Timing Sequencer

This block produces the slot, subframe and block timing for a two-channel biphase digital audio transmitter. It runs on the serial bit clock. Each subframe has 32 bit slots, each frame holds a left subframe followed by a right one, and 192 frames make one channel-status block. For every slot the block reports the slot number, the channel, the frame number inside the block, which preamble the subframe starts with, and what the slot carries. Biphase-mark encoding and parity generation are done downstream from these indices.

After reset the counters stay idle and the line is held at ground. The block then waits for the frame-sync input to show its active edge. In left/right mode that is the move into the right-channel phase. In word-pulse mode it is the rising edge of the pulse. Counting starts eight and a half bit periods later. A half-cycle arm is set on the falling clock edge, and the counters start on the rising edge that follows it. Because the start is tied to the right-channel phase, channel A always carries the left sample and channel B the right sample. A block-start strobe runs one slot ahead of the block boundaries, so serial channel-status loaders can line up with it.

Top module: `audio_frame_sequencer`

## Requirements
- R1: While `rstN` is low, and starting at the moment it falls (asynchronously), the outputs are: `lineIdle`=1, `cbl`=0, `bitIdx`=0, `chanB`=0, `frameIdx`=0, `preamble`=0 and `slotKind`=7.
- R2: With `wordSync`=0, `fsync` is a left/right clock (high = left phase). The active edge is a rising-`sck` sample of `fsync`=0 that follows a sample of `fsync`=1 taken after reset. A low level when reset is released does not start the counters, and neither does a rising edge.
- R3: With `wordSync`=1, `fsync` is a word pulse. The active edge is a sample of `fsync`=1 that follows a sample of `fsync`=0 taken after reset. A high level held from reset release does not start the counters.
- R4: Take the rising `sck` edge that first samples the active edge. `lineIdle` falls on the eighth rising edge after it, through an arm flag set on the falling edge just before. The first slot then shown is bit 0 of channel A in frame 0.
- R5: Once running, the block ignores `fsync` and `wordSync`, and it keeps running until the next reset.
- R6: `bitIdx` steps 0 to 31, one slot per rising edge. `chanB` (0 = A/left, 1 = B/right) toggles each time `bitIdx` wraps from 31 to 0.
- R7: `frameIdx` increments after slot 31 of channel B, and wraps from 191 to 0.
- R8: The `preamble` codes are 1 = Z for channel A of frame 0, 2 = X for channel A of any other frame, 3 = Y for channel B, and 0 while idle.
- R9: The `slotKind` codes are 0 for preamble slots 0–3, 1 for auxiliary slots 4–7, and 2 for audio slots 8–27, with the LSB at slot 8. Slots 28, 29, 30 and 31 give 3 (validity), 4 (user), 5 (channel status) and 6 (parity). The code is 7 while idle.
- R10: `cbl` is high in every running slot whose next slot lies in frames 0–127. It therefore rises in slot 31 of channel B of frame 191 and falls in slot 31 of channel B of frame 127. It is also high from the first slot after start-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial bit clock; counters advance on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync: left/right clock or word pulse |
| wordSync | input | 1 | 1 = `fsync` is a word pulse, 0 = left/right clock |
| lineIdle | output | 1 | High while the line must be held at ground (not running) |
| bitIdx | output | 5 | Slot number within the subframe |
| chanB | output | 1 | Subframe select, 0 = channel A (left), 1 = channel B (right) |
| frameIdx | output | 8 | Frame number within the channel-status block |
| preamble | output | 2 | Preamble type of the current subframe |
| slotKind | output | 3 | Content class of the current slot |
| cbl | output | 1 | Block-start strobe, one slot ahead of frame 0 and frame 128 |

## Verification
The busiest cycle is slot 31 of channel B in frame 191. In that one edge the slot counter, the channel select and the frame counter all wrap, the block-start strobe rises, and the next subframe switches to preamble Z. A second coincidence comes in slot 31 of channel B in frame 127, where the frame count advances as the strobe falls. The bench provokes both by running straight through two full blocks in left/right mode and one in word-pulse mode, with `fsync` still toggling. Every slot is compared with indices the bench works out from the number of slots elapsed since the start edge.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;  // load counters to the first slot of a block
    logic step;   // advance one slot
  } seq_strobe_t;

  typedef enum logic [1:0] {
    PRE_NONE = 2'd0,
    PRE_Z    = 2'd1,
    PRE_X    = 2'd2,
    PRE_Y    = 2'd3
  } preamble_e;

  typedef enum logic [2:0] {
    SLOT_PRE    = 3'd0,
    SLOT_AUX    = 3'd1,
    SLOT_AUDIO  = 3'd2,
    SLOT_VALID  = 3'd3,
    SLOT_USER   = 3'd4,
    SLOT_CHSTAT = 3'd5,
    SLOT_PARITY = 3'd6,
    SLOT_IDLE   = 3'd7
  } slot_e;

endpackage

// File: rtl/tx_seq_ctrl.sv
module tx_seq_ctrl
  import tx_seq_pkg::*;
#(
  parameter int START_DELAY = 8
) (
  input  logic        sck,
  input  logic        rstN,
  input  logic        fsync,
  input  logic        wordSync,
  output seq_strobe_t strobe,
  output logic        running
);

  localparam int DW = $clog2(START_DELAY + 1);
  localparam logic [DW-1:0] LAST_WAIT = DW'(START_DELAY - 1);

  typedef enum logic [1:0] {ST_SEEK, ST_DELAY, ST_RUN} state_e;

  state_e        state;
  logic          seenIdle;
  logic [DW-1:0] dlyCnt;
  logic          armReq;
  logic          armed;
  logic          idleLevel;
  logic          activeEdge;

  // Idle level: left phase (high) for a left/right clock, low for a word pulse
  assign idleLevel  = wordSync ? ~fsync : fsync;
  assign activeEdge = (state == ST_SEEK) && seenIdle && !idleLevel;

  always_ff @(posedge sck or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_SEEK;
      seenIdle <= 1'b0;
      dlyCnt   <= '0;
    end else begin
      case (state)
        ST_SEEK: begin
          if (idleLevel) seenIdle <= 1'b1;
          if (activeEdge) begin
            state  <= ST_DELAY;
            dlyCnt <= '0;
          end
        end
        ST_DELAY: begin
          if (armed) state <= ST_RUN;
          else if (dlyCnt != LAST_WAIT) dlyCnt <= dlyCnt + 1'b1;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign armReq = (state == ST_DELAY) && (dlyCnt == LAST_WAIT);

  // Half-period step of the start delay: arm on the falling edge
  always_ff @(negedge sck or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= armReq;
  end

  assign strobe.start = (state == ST_DELAY) && armed;
  assign strobe.step  = (state == ST_RUN);
  assign running      = (state == ST_RUN);

  assert_arm_before_run_R4: assert property (@(posedge sck) disable iff (!rstN)
    $rose(running) |-> $past(armed));

  assert_run_sticky_R5: assert property (@(posedge sck) disable iff (!rstN)
    running |=> running);

  assert_start_after_edge_R2: assert property (@(posedge sck) disable iff (!rstN)
    $rose(state == ST_DELAY) |-> $past(seenIdle));

endmodule

// File: rtl/tx_seq_datapath.sv
module tx_seq_datapath
  import tx_seq_pkg::*;
#(
  parameter int BIT_SLOTS  = 32,
  parameter int FRAMES     = 192,
  parameter int CBL_FRAMES = 128,
  parameter int PRE_SLOTS  = 4,
  parameter int AUX_SLOTS  = 4,
  parameter int BW         = $clog2(BIT_SLOTS),
  parameter int FW         = $clog2(FRAMES)
) (
  input  logic          sck,
  input  logic          rstN,
  input  seq_strobe_t   strobe,
  input  logic          running,
  output logic [BW-1:0] bitIdx,
  output logic          chanB,
  output logic [FW-1:0] frameIdx,
  output preamble_e     preamble,
  output slot_e         slotKind,
  output logic          cbl
);

  localparam logic [BW-1:0] LAST_BIT   = BW'(BIT_SLOTS - 1);
  localparam logic [FW-1:0] LAST_FRAME = FW'(FRAMES - 1);
  localparam int AUDIO_FIRST = PRE_SLOTS + AUX_SLOTS;
  localparam int TAIL_FIRST  = BIT_SLOTS - 4;   // V, U, C, P

  logic          lastBit;
  logic          lastFrame;
  logic [FW-1:0] nextFrame;

  assign lastBit   = (bitIdx == LAST_BIT);
  assign lastFrame = (frameIdx == LAST_FRAME);

  always_ff @(posedge sck or negedge rstN) begin
    if (!rstN) begin
      bitIdx   <= '0;
      chanB    <= 1'b0;
      frameIdx <= '0;
    end else if (strobe.start) begin
      bitIdx   <= '0;
      chanB    <= 1'b0;
      frameIdx <= '0;
    end else if (strobe.step) begin
      bitIdx <= lastBit ? '0 : bitIdx + 1'b1;
      if (lastBit) chanB <= ~chanB;
      if (lastBit && chanB) frameIdx <= lastFrame ? '0 : frameIdx + 1'b1;
    end
  end

  // Frame index of the slot that follows the current one
  always_comb begin
    nextFrame = frameIdx;
    if (lastBit && chanB) nextFrame = lastFrame ? '0 : frameIdx + 1'b1;
  end

  assign cbl = running && (int'(nextFrame) < CBL_FRAMES);

  always_comb begin
    if (!running)            preamble = PRE_NONE;
    else if (chanB)          preamble = PRE_Y;
    else if (frameIdx == '0) preamble = PRE_Z;
    else                     preamble = PRE_X;
  end

  always_comb begin
    if (!running)                          slotKind = SLOT_IDLE;
    else if (int'(bitIdx) < PRE_SLOTS)     slotKind = SLOT_PRE;
    else if (int'(bitIdx) < AUDIO_FIRST)   slotKind = SLOT_AUX;
    else if (int'(bitIdx) < TAIL_FIRST)    slotKind = SLOT_AUDIO;
    else begin
      case (int'(bitIdx) - TAIL_FIRST)
        0:       slotKind = SLOT_VALID;
        1:       slotKind = SLOT_USER;
        2:       slotKind = SLOT_CHSTAT;
        default: slotKind = SLOT_PARITY;
      endcase
    end
  end

  assert_chan_toggle_R6: assert property (@(posedge sck) disable iff (!rstN)
    (strobe.step && lastBit) |=> (chanB != $past(chanB)));

  assert_frame_wrap_R7: assert property (@(posedge sck) disable iff (!rstN)
    (strobe.step && lastBit && chanB && lastFrame) |=> (frameIdx == '0 && !chanB));

  assert_cbl_fall_R10: assert property (@(posedge sck) disable iff (!rstN)
    ($fell(cbl) && running) |-> (int'(frameIdx) == CBL_FRAMES - 1 && chanB && lastBit));

  assert_z_only_first_R8: assert property (@(posedge sck) disable iff (!rstN)
    (preamble == PRE_Z) |-> (frameIdx == '0 && !chanB));

  assert_start_slot_R4: assert property (@(posedge sck) disable iff (!rstN)
    strobe.start |=> (bitIdx == '0 && !chanB && frameIdx == '0));

endmodule

// File: rtl/audio_frame_sequencer.sv
module audio_frame_sequencer
  import tx_seq_pkg::*;
#(
  parameter int BIT_SLOTS   = 32,
  parameter int FRAMES      = 192,
  parameter int CBL_FRAMES  = 128,
  parameter int START_DELAY = 8,
  parameter int BW          = $clog2(BIT_SLOTS),
  parameter int FW          = $clog2(FRAMES)
) (
  input  logic          sck,
  input  logic          rstN,
  input  logic          fsync,
  input  logic          wordSync,
  output logic          lineIdle,
  output logic [BW-1:0] bitIdx,
  output logic          chanB,
  output logic [FW-1:0] frameIdx,
  output logic [1:0]    preamble,
  output logic [2:0]    slotKind,
  output logic          cbl
);

  seq_strobe_t strobe;
  logic        running;
  preamble_e   preSel;
  slot_e       kindSel;

  tx_seq_ctrl #(.START_DELAY(START_DELAY)) u_ctrl (
    .sck      (sck),
    .rstN     (rstN),
    .fsync    (fsync),
    .wordSync (wordSync),
    .strobe   (strobe),
    .running  (running)
  );

  tx_seq_datapath #(
    .BIT_SLOTS  (BIT_SLOTS),
    .FRAMES     (FRAMES),
    .CBL_FRAMES (CBL_FRAMES),
    .BW         (BW),
    .FW         (FW)
  ) u_dp (
    .sck      (sck),
    .rstN     (rstN),
    .strobe   (strobe),
    .running  (running),
    .bitIdx   (bitIdx),
    .chanB    (chanB),
    .frameIdx (frameIdx),
    .preamble (preSel),
    .slotKind (kindSel),
    .cbl      (cbl)
  );

  assign lineIdle = ~running;
  assign preamble = preSel;
  assign slotKind = kindSel;

endmodule

// File: tb/audio_frame_sequencer_tb.sv
`timescale 1ns/1ps
module audio_frame_sequencer_tb;

  logic       sck = 1'b0;
  logic       rstN;
  logic       fsync;
  logic       wordSync;
  logic       lineIdle;
  logic [4:0] bitIdx;
  logic       chanB;
  logic [7:0] frameIdx;
  logic [1:0] preamble;
  logic [2:0] slotKind;
  logic       cbl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 sck = ~sck;

  audio_frame_sequencer u_dut (
    .sck(sck), .rstN(rstN), .fsync(fsync), .wordSync(wordSync),
    .lineIdle(lineIdle), .bitIdx(bitIdx), .chanB(chanB), .frameIdx(frameIdx),
    .preamble(preamble), .slotKind(slotKind), .cbl(cbl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkIdle(input string req);
    chk(lineIdle == 1'b1, req, lineIdle, 1);
    chk(cbl == 1'b0, req, cbl, 0);
    chk(bitIdx == 0 && !chanB && frameIdx == 0, req, {frameIdx, chanB, bitIdx}, 0);
    chk(preamble == 2'd0, req, preamble, 0);
    chk(slotKind == 3'd7, req, slotKind, 7);
  endtask

  function automatic int expKind(input int b);
    if (b < 4)  return 0;
    if (b < 8)  return 1;
    if (b < 28) return 2;
    return 3 + (b - 28);
  endfunction

  // Called at the falling edge on which the active fsync level was driven.
  task automatic startCheck(input bit pulseMode);
    @(posedge sck);
    if (pulseMode) fsync = 1'b1;  // held through the detecting edge
    for (int k = 0; k <= 8; k++) begin
      @(negedge sck);
      if (k == 0 && pulseMode) fsync = 1'b0;
      chk(lineIdle == (k != 8), "R4", lineIdle, (k != 8));
    end
  endtask

  // Called at the falling edge where slot 0 is visible.
  task automatic runSlots(input int count, input bit pulseMode);
    for (int n = 0; n < count; n++) begin
      int b = n % 32;
      int c = (n / 32) % 2;
      int f = (n / 64) % 192;
      int pre = c ? 3 : ((f == 0) ? 1 : 2);
      int nf = ((n + 1) / 64) % 192;
      chk(lineIdle == 1'b0, "R5", lineIdle, 0);
      chk(int'(bitIdx) == b, "R6", bitIdx, b);
      chk(int'(chanB) == c, "R6", chanB, c);
      chk(int'(frameIdx) == f, "R7", frameIdx, f);
      chk(int'(preamble) == pre, "R8", preamble, pre);
      chk(int'(slotKind) == expKind(b), "R9", slotKind, expKind(b));
      chk(int'(cbl) == (nf < 128), "R10", cbl, (nf < 128));
      // R5: keep fsync moving; the running counters must not react
      if (pulseMode) fsync = (n % 32 == 5);
      else           fsync = ((n / 16) % 2 == 0);
      if (n == 1000) wordSync = ~wordSync;
      @(negedge sck);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    rstN = 1'b0; fsync = 1'b0; wordSync = 1'b0;
    repeat (4) @(negedge sck);
    chkIdle("R1");

    // Left/right mode: low at release and a rising edge must not start
    rstN = 1'b1;
    repeat (10) @(negedge sck);
    chk(lineIdle == 1'b1, "R2", lineIdle, 1);
    fsync = 1'b1;
    repeat (10) @(negedge sck);
    chk(lineIdle == 1'b1, "R2", lineIdle, 1);
    chk(slotKind == 3'd7, "R2", slotKind, 7);
    fsync = 1'b0;   // into right phase: active edge
    startCheck(1'b0);
    runSlots(2 * 12288 + 70, 1'b0);

    // Asynchronous reset in the middle of a subframe
    #1 rstN = 1'b0;
    #1 chkIdle("R1");
    @(negedge sck);
    chkIdle("R1");

    // Word-pulse mode: high held from release must not start
    wordSync = 1'b1; fsync = 1'b1;
    @(negedge sck);
    rstN = 1'b1;
    repeat (12) @(negedge sck);
    chk(lineIdle == 1'b1, "R3", lineIdle, 1);
    fsync = 1'b0;
    repeat (3) @(negedge sck);
    chk(lineIdle == 1'b1, "R3", lineIdle, 1);
    fsync = 1'b1;   // pulse rises: active edge
    startCheck(1'b1);
    runSlots(12288 + 200, 1'b1);

    finishRun();
  end

endmodule